// File: doc/BRIEF.md
# Power-Down Controller with Shutdown Lockout

This block sets the power state of the digital core of a four-channel DAC. Software can ask for shutdown through a decoded command nibble. While the block is shut down, the output buffers and reference inputs are modelled as high impedance through the `pwr_down` flag. The serial interface keeps running during shutdown, and the input and DAC registers outside this block keep their contents. Waking therefore brings back the outputs that were present before shutdown.

An active-low lockout pin controls whether software shutdown is allowed. While the pin is low, shutdown commands are ignored. A high-to-low edge on the pin during shutdown wakes the device without any command. The pin is asynchronous, so it passes through a two-flop synchroniser before the edge detector.

Every wake starts a settle counter of 15 µs worth of clock cycles (1875 cycles at 125 MHz). `outs_valid` stays low until that count runs out.

Top module: `pd_lockout_ctrl`

## Requirements
- R1: After power-on reset, `pwr_down` is 0 and `outs_valid` is 1.
- R2: A command with nibble 4'b1100 enters shutdown on the next clock edge if the synchronised lockout pin is high. `pwr_down` then reads 1 and `outs_valid` reads 0.
- R3: In shutdown, commands that do not update the DAC registers leave the block in shutdown. These are 4'b0000, 4'b0010, 4'b0110, 4'b0001 and 4'b1100.
- R4: In shutdown, the update-all command 4'b0100 or the load-all command 4'b1000 clears `pwr_down` on the next clock edge.
- R5: In shutdown, any other command that updates the DAC registers also exits shutdown. These are the nibbles whose two low bits are 2'b11, plus 4'b1110 and 4'b1010.
- R6: `outs_valid` rises exactly SETTLE_CYC clock edges after the edge on which `pwr_down` falls. It stays low until then.
- R7: While the synchronised lockout pin is low, a shutdown command is ignored and `pwr_down` stays 0.
- R8: In shutdown, a falling edge on `lockout_n` clears `pwr_down` on the third rising clock edge after the pin falls. That is two synchroniser stages plus one state update. The settle time of R6 then follows.
- R9: A falling edge on `lockout_n` outside shutdown has no effect on `pwr_down` or `outs_valid`.
- R10: A wake command outside shutdown does not restart the settle counter. `outs_valid` stays 1.
- R11: `clr_n` low at a clock edge returns the block to normal mode with `pwr_down` 0 and `outs_valid` 1. This holds from shutdown or from settling.
- R12: A shutdown command issued while settling enters shutdown. A later wake then waits the full SETTLE_CYC again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low power-on reset |
| clr_n | input | 1 | Synchronous active-low clear |
| cmd_valid | input | 1 | Command nibble valid for one cycle |
| cmd_code | input | 4 | Address/control nibble, bit 3 first on the wire |
| lockout_n | input | 1 | Asynchronous active-low shutdown lockout pin |
| pwr_down | output | 1 | 1 = outputs and references high impedance |
| outs_valid | output | 1 | 1 = outputs settled and valid |

## Verification
The bench measures the settle window to the exact edge on both sides. A counter that is off by one shows `outs_valid` one cycle early or one cycle late. It checks the lockout wake latency of three edges. A design without the synchroniser, or one that waits an extra cycle, wakes at the wrong sample. It sends non-update commands during shutdown and wake commands while active. This exposes a decoder that wakes too eagerly or restarts settling on every update. It also issues a shutdown while the lockout pin is held low, and pulls the pin low outside shutdown. Both catch a design that gates shutdown on the raw pin or reacts to any lockout edge.

// File: rtl/pd_lockout_ctrl.sv
module pd_lockout_ctrl #(
  parameter int CLK_HZ    = 125_000_000,
  parameter int SETTLE_NS = 15_000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       clr_n,
  input  logic       cmd_valid,
  input  logic [3:0] cmd_code,
  input  logic       lockout_n,
  output logic       pwr_down,
  output logic       outs_valid
);
  localparam int SETTLE_CYC = (CLK_HZ / 1_000_000) * SETTLE_NS / 1000;
  localparam int CW = $clog2(SETTLE_CYC + 1);

  logic          lk_s1, lk_s2, lk_d;
  logic [CW-1:0] cnt;
  logic          lk_fall, is_sd, is_upd, wake;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) {lk_s1, lk_s2, lk_d} <= 3'b111;
    else        {lk_s1, lk_s2, lk_d} <= {lockout_n, lk_s1, lk_s2};

  assign lk_fall = lk_d & ~lk_s2;
  assign is_sd   = cmd_valid && cmd_code == 4'b1100;
  assign is_upd  = cmd_valid && (cmd_code[1:0] == 2'b11 || cmd_code == 4'b0100 ||
                                 cmd_code == 4'b1000 || cmd_code == 4'b1110 ||
                                 cmd_code == 4'b1010);
  assign wake    = lk_fall | is_upd;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      pwr_down <= 1'b0;
      cnt      <= '0;
    end else if (!clr_n) begin
      pwr_down <= 1'b0;
      cnt      <= '0;
    end else if (pwr_down) begin
      if (wake) begin
        pwr_down <= 1'b0;
        cnt      <= CW'(SETTLE_CYC);
      end
    end else if (is_sd && lk_s2) begin
      pwr_down <= 1'b1;
      cnt      <= '0;
    end else if (cnt != '0) begin
      cnt <= cnt - 1'b1;
    end

  assign outs_valid = ~pwr_down & (cnt == '0);

  // R2
  assert_sd_enter_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_n && !pwr_down && is_sd && lk_s2) |=> (pwr_down && !outs_valid));
  // R7
  assert_lockout_blocks_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!pwr_down && !lk_s2) |=> !pwr_down);
  // R3
  assert_pd_retained_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (pwr_down && clr_n && !lk_fall && !is_upd) |=> pwr_down);
  // R4, R5, R8
  assert_wake_exit_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (pwr_down && clr_n && wake) |=> (!pwr_down && !outs_valid));
  // R6
  assert_settle_end_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_n && !pwr_down && !is_sd && cnt == CW'(1)) |=> outs_valid);
  // R10
  assert_no_restart_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_n && outs_valid && !is_sd) |=> outs_valid);
  // R11
  assert_clear_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !clr_n |=> (!pwr_down && outs_valid));
endmodule

// File: tb/test_pd_lockout_ctrl.sv
`timescale 1ns/1ps
module test_pd_lockout_ctrl;
  localparam int N = 15000 / 8;

  logic clk = 0, rst_n = 0, clr_n = 1, cmd_valid = 0, lockout_n = 1;
  logic [3:0] cmd_code = 4'b0000;
  logic pwr_down, outs_valid;
  int checks = 0, fails = 0;
  bit done = 0;

  always #4 clk = ~clk;

  pd_lockout_ctrl i_pd_lockout_ctrl (
    .clk(clk), .rst_n(rst_n), .clr_n(clr_n), .cmd_valid(cmd_valid),
    .cmd_code(cmd_code), .lockout_n(lockout_n),
    .pwr_down(pwr_down), .outs_valid(outs_valid));

  task automatic chk(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%b expected=%b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic send(input logic [3:0] c);
    @(negedge clk); cmd_valid = 1; cmd_code = c;
    @(negedge clk); cmd_valid = 0; cmd_code = 4'b0000;
  endtask

  task automatic settle_check(input string req);
    repeat (N - 1) @(negedge clk);
    chk({req, " still settling"}, outs_valid, 1'b0);
    @(negedge clk);
    chk({req, " settled"}, outs_valid, 1'b1);
  endtask

  task automatic t_reset_r1;
    chk("R1 pwr_down", pwr_down, 1'b0);
    chk("R1 outs_valid", outs_valid, 1'b1);
  endtask

  task automatic t_enter_r2;
    send(4'b1100);
    chk("R2 pwr_down", pwr_down, 1'b1);
    chk("R2 outs_valid", outs_valid, 1'b0);
  endtask

  task automatic t_nonupd_r3;
    logic [3:0] codes [5] = '{4'b0000, 4'b0010, 4'b0110, 4'b0001, 4'b1100};
    for (int i = 0; i < 5; i++) begin
      send(codes[i]);
      chk("R3 stays down", pwr_down, 1'b1);
    end
  endtask

  task automatic t_cmd_wake_r4(input logic [3:0] c);
    t_enter_r2();
    send(c);
    chk("R4 wake", pwr_down, 1'b0);
    chk("R4 not yet valid", outs_valid, 1'b0);
    settle_check("R6");
  endtask

  task automatic t_other_wake_r5(input logic [3:0] c);
    t_enter_r2();
    send(c);
    chk("R5 wake", pwr_down, 1'b0);
    settle_check("R5/R6");
  endtask

  task automatic t_lockout_blocks_r7;
    @(negedge clk); lockout_n = 0;
    repeat (3) @(negedge clk);
    send(4'b1100);
    chk("R7 ignored", pwr_down, 1'b0);
    chk("R7 valid kept", outs_valid, 1'b1);
    @(negedge clk); lockout_n = 1;
    repeat (3) @(negedge clk);
  endtask

  task automatic t_lockout_wake_r8;
    t_enter_r2();
    @(negedge clk); lockout_n = 0;
    repeat (2) @(negedge clk);
    chk("R8 before third edge", pwr_down, 1'b1);
    @(negedge clk);
    chk("R8 woke on third edge", pwr_down, 1'b0);
    settle_check("R8");
    lockout_n = 1;
    repeat (3) @(negedge clk);
  endtask

  task automatic t_lockout_idle_r9;
    @(negedge clk); lockout_n = 0;
    repeat (5) @(negedge clk);
    chk("R9 pwr_down", pwr_down, 1'b0);
    chk("R9 outs_valid", outs_valid, 1'b1);
    lockout_n = 1;
    repeat (3) @(negedge clk);
  endtask

  task automatic t_no_restart_r10;
    send(4'b0100);
    chk("R10 valid after update", outs_valid, 1'b1);
    send(4'b1000);
    @(negedge clk);
    chk("R10 valid after load", outs_valid, 1'b1);
  endtask

  task automatic t_clear_r11;
    t_enter_r2();
    @(negedge clk); clr_n = 0;
    @(negedge clk); clr_n = 1;
    chk("R11 from shutdown pwr_down", pwr_down, 1'b0);
    chk("R11 from shutdown valid", outs_valid, 1'b1);
    t_enter_r2();
    send(4'b0100);
    repeat (10) @(negedge clk);
    clr_n = 0;
    @(negedge clk); clr_n = 1;
    chk("R11 from settling valid", outs_valid, 1'b1);
  endtask

  task automatic t_sd_while_settling_r12;
    t_enter_r2();
    send(4'b0100);
    repeat (20) @(negedge clk);
    send(4'b1100);
    chk("R12 re-entered", pwr_down, 1'b1);
    send(4'b1000);
    chk("R12 woke", pwr_down, 1'b0);
    settle_check("R12");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset_r1();
    t_enter_r2();
    t_nonupd_r3();
    send(4'b0100);
    settle_check("R4");
    t_cmd_wake_r4(4'b0100);
    t_cmd_wake_r4(4'b1000);
    t_other_wake_r5(4'b0011);
    t_other_wake_r5(4'b1110);
    t_other_wake_r5(4'b1010);
    t_lockout_blocks_r7();
    t_lockout_wake_r8();
    t_lockout_idle_r9();
    t_no_restart_r10();
    t_clear_r11();
    t_sd_while_settling_r12();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule